// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is a single-select SPI master that a processor drives through three 16-bit registers. Software sets up the control word (enable, one- or two-byte transfers, clock phase and idle level, clock divider, interrupt enables) and then writes the data register. That write launches a transfer. The engine pulls chip select low and shifts the word out MSB first on MOSI while it captures MISO. When the transfer ends it releases the select, puts the received word into the same data register and raises the status flags. A read of the data register returns the received word and clears the status. A single level-sensitive interrupt line reports completion and the idle condition.

The shift engine has four states. It waits in IDLE. IDLE moves to LEAD on a start, and LEAD holds the select low for one half-period of setup. LEAD moves to SHIFT on the next divider tick. SHIFT produces two clock edges per bit. After the trailing edge of the last bit it moves to TAIL, which holds the select low for one more half-period. TAIL returns to IDLE on the next tick, and the received word is committed on that same tick. A separate divider makes one tick every half-period, and only while the engine is out of IDLE.

Top module: `spi_host_regs`

## Requirements
- R1: After reset every register reads zero, `cs_n` is 1, `sclk` is 0 and `irq` is 0.
- R2: The control register sits at byte offset 0x2 and is written per byte lane through `bus_be`. The fields are: bit 0 enable, bit 2 two-byte mode, bit 5 receive interrupt enable, bit 6 idle interrupt enable, bit 7 clock phase, bit 8 clock idle level, bits 15:9 divider. The other bits always read 0, so a full write of 0xFFFF reads back as 0xFFE5.
- R3: When the enable bit is set, a write to the data register (offset 0x0) starts a transfer on the next clock edge. `cs_n` goes low for the whole transfer and returns high afterwards. In one-byte mode only the lower written byte is sent, MSB first.
- R4: In two-byte mode the upper byte is sent first and then the lower byte, each MSB first. The first received byte lands in bits 15:8 of the data register and the second in bits 7:0.
- R5: In one-byte mode the received byte lands in bits 7:0 of the data register and bits 15:8 read 0.
- R6: Each `sclk` half-period lasts (divider+1)*2 clocks. While `cs_n` is high, `sclk` equals the control idle-level bit.
- R7: With phase 0, MISO is sampled on the edge that leaves the idle level and MOSI changes on the edge that returns to it. With phase 1 the two edges swap roles.
- R8: The status register sits at offset 0x4, with bit 0 busy and bit 1 receive-full. A start sets busy and clears receive-full. Completion sets both bits, so the register reads 0x0003.
- R9: A read of the data register returns the received word and clears both status bits.
- R10: `irq` is 1 only while the enable bit is set, and then only when busy is 0 with the idle interrupt enabled, or when receive-full is 1 with the receive interrupt enabled.
- R11: A write to the data register is ignored while a transfer is running or while the enable bit is clear.
- R12: A read of an unmapped offset returns 0. A write to the status register or to an unmapped offset changes nothing. An access with `bus_addr[0]` set is misaligned: it reads 0 and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address inside the register window |
| bus_be | input | 2 | Byte-lane enables for writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the cycle of the access |
| irq | output | 1 | Level-sensitive interrupt |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
The hardest case to reach from the ports is a second data write that arrives while the first transfer is still shifting. Such a write must leave no trace, neither on the wire nor in the stored result. The bench sets a slow divider so the transfer spans well over a hundred clocks. It reads status in the middle of the transfer, which should show busy alone. It then writes a different word and checks that the slave model received only the first word. The table-driven part pairs the engine with a behavioural slave for every combination of phase, idle level and width. That slave shifts from its own edge rules, so a swapped sampling edge or byte order shows up as a wrong word rather than as a timing detail.

// File: rtl/spi_regs_pkg.sv
`timescale 1ns/1ps
package spi_regs_pkg;
    localparam int REG_W  = 16;
    localparam int BYTE_W = 8;
    localparam int DIV_W  = 7;
    localparam int BIT_W  = $clog2(REG_W);

    // word indices (byte offset / 2); decoded by software, so kept fixed
    localparam int OFS_DATA = 0;
    localparam int OFS_CTL  = 1;
    localparam int OFS_STAT = 2;

    localparam int CTL_EN    = 0;
    localparam int CTL_WIDE  = 2;
    localparam int CTL_RXIE  = 5;
    localparam int CTL_TXIE  = 6;
    localparam int CTL_PHASE = 7;
    localparam int CTL_IDLE  = 8;
    localparam int CTL_DIV   = 9;
    localparam logic [REG_W-1:0] CTL_MASK = 16'hFFE5;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_LEAD,
        ENG_SHIFT,
        ENG_TAIL
    } eng_state_t;

    typedef struct packed {
        logic             wide;
        logic             phase;
        logic             idle;
        logic [DIV_W-1:0] div;
    } xfer_cfg_t;
endpackage

// File: rtl/spi_clk_div.sv
`timescale 1ns/1ps
module spi_clk_div #(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int CNT_W = DIV_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    // (div+1)*2 - 1 = 2*div + 1
    assign limit = {div, 1'b1};
    assign tick  = run && (cnt_q >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/spi_shift_engine.sv
`timescale 1ns/1ps
module spi_shift_engine
    import spi_regs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  xfer_cfg_t        cfg_in,
    input  logic [REG_W-1:0] tx_word,
    input  logic             idle_lvl,
    input  logic             miso,
    input  logic             tick,
    output logic             busy,
    output logic             done,
    output logic [REG_W-1:0] rx_word,
    output logic [DIV_W-1:0] div_q,
    output logic             sclk,
    output logic             mosi,
    output logic             cs_n
);
    eng_state_t       state, state_d;
    xfer_cfg_t        cfg_q;
    logic [REG_W-1:0] tx_q, rx_q, load_word;
    logic [BIT_W-1:0] bit_idx;
    logic             phase_q, sclk_q, mosi_q, cs_n_q;
    logic             last_bit;

    assign load_word = cfg_in.wide ? tx_word : {tx_word[BYTE_W-1:0], {BYTE_W{1'b0}}};
    assign last_bit  = bit_idx == (cfg_q.wide ? BIT_W'(REG_W - 1) : BIT_W'(BYTE_W - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ENG_IDLE;
        else        state <= state_d;
    end

    always_comb begin
        state_d = state;
        unique case (state)
            ENG_IDLE:  if (start) state_d = ENG_LEAD;
            ENG_LEAD:  if (tick) state_d = ENG_SHIFT;
            ENG_SHIFT: if (tick && phase_q && last_bit) state_d = ENG_TAIL;
            ENG_TAIL:  if (tick) state_d = ENG_IDLE;
            default:   state_d = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            tx_q    <= '0;
            rx_q    <= '0;
            bit_idx <= '0;
            phase_q <= 1'b0;
            sclk_q  <= 1'b0;
            mosi_q  <= 1'b0;
            cs_n_q  <= 1'b1;
        end else begin
            unique case (state)
                ENG_IDLE: begin
                    if (start) begin
                        cfg_q   <= cfg_in;
                        tx_q    <= load_word;
                        rx_q    <= '0;
                        bit_idx <= '0;
                        phase_q <= 1'b0;
                        sclk_q  <= cfg_in.idle;
                        mosi_q  <= load_word[REG_W-1];
                        cs_n_q  <= 1'b0;
                    end
                end
                ENG_LEAD: begin
                    phase_q <= 1'b0;
                end
                ENG_SHIFT: begin
                    if (tick && !phase_q) begin
                        sclk_q  <= ~cfg_q.idle;
                        phase_q <= 1'b1;
                        if (!cfg_q.phase) rx_q   <= {rx_q[REG_W-2:0], miso};
                        else              mosi_q <= tx_q[REG_W-1];
                    end else if (tick) begin
                        sclk_q  <= cfg_q.idle;
                        phase_q <= 1'b0;
                        bit_idx <= bit_idx + 1'b1;
                        tx_q    <= {tx_q[REG_W-2:0], 1'b0};
                        if (cfg_q.phase) rx_q   <= {rx_q[REG_W-2:0], miso};
                        else             mosi_q <= tx_q[REG_W-2];
                    end
                end
                ENG_TAIL: begin
                    if (tick) cs_n_q <= 1'b1;
                end
                default: cs_n_q <= 1'b1;
            endcase
        end
    end

    assign busy    = state != ENG_IDLE;
    assign done    = (state == ENG_TAIL) && tick;
    assign rx_word = cfg_q.wide ? rx_q : {{BYTE_W{1'b0}}, rx_q[BYTE_W-1:0]};
    assign div_q   = cfg_q.div;
    assign sclk    = (state == ENG_IDLE) ? idle_lvl : sclk_q;
    assign mosi    = mosi_q;
    assign cs_n    = cs_n_q;
endmodule

// File: rtl/spi_reg_file.sv
`timescale 1ns/1ps
module spi_reg_file
    import spi_regs_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_be,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              eng_busy,
    input  logic              eng_done,
    input  logic [REG_W-1:0]  rx_word,
    output logic              start,
    output logic [REG_W-1:0]  tx_word,
    output xfer_cfg_t         cfg,
    output logic              idle_lvl,
    output logic              stat_bsy,
    output logic              stat_rbf,
    output logic              irq
);
    localparam int WIDX_W = ADDR_W - 1;
    localparam int LANES  = REG_W / BYTE_W;

    logic [WIDX_W-1:0] widx;
    logic              acc_ok, hit_data, hit_ctl, hit_stat;
    logic              wr_data, wr_ctl, rd_data;
    logic [REG_W-1:0]  ctl_q, data_q;
    logic              bsy_q, rbf_q;

    assign widx     = bus_addr[ADDR_W-1:1];
    assign acc_ok   = bus_sel && !bus_addr[0];
    assign hit_data = widx == WIDX_W'(OFS_DATA);
    assign hit_ctl  = widx == WIDX_W'(OFS_CTL);
    assign hit_stat = widx == WIDX_W'(OFS_STAT);
    assign wr_data  = acc_ok && bus_wr && hit_data && (|bus_be);
    assign wr_ctl   = acc_ok && bus_wr && hit_ctl;
    assign rd_data  = acc_ok && !bus_wr && hit_data;

    assign start = wr_data && ctl_q[CTL_EN] && !eng_busy;

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            assign tx_word[g*BYTE_W +: BYTE_W] = bus_be[g] ? bus_wdata[g*BYTE_W +: BYTE_W] : '0;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    ctl_q[g*BYTE_W +: BYTE_W] <= '0;
                else if (wr_ctl && bus_be[g])
                    ctl_q[g*BYTE_W +: BYTE_W] <= bus_wdata[g*BYTE_W +: BYTE_W] & CTL_MASK[g*BYTE_W +: BYTE_W];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            bsy_q  <= 1'b0;
            rbf_q  <= 1'b0;
        end else if (eng_done) begin
            data_q <= rx_word;
            bsy_q  <= 1'b1;
            rbf_q  <= 1'b1;
        end else if (start) begin
            bsy_q  <= 1'b1;
            rbf_q  <= 1'b0;
        end else if (rd_data) begin
            bsy_q  <= 1'b0;
            rbf_q  <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (acc_ok && !bus_wr) begin
            if (hit_data)      bus_rdata = data_q;
            else if (hit_ctl)  bus_rdata = ctl_q;
            else if (hit_stat) bus_rdata = {{(REG_W-2){1'b0}}, rbf_q, bsy_q};
        end
    end

    assign cfg.wide  = ctl_q[CTL_WIDE];
    assign cfg.phase = ctl_q[CTL_PHASE];
    assign cfg.idle  = ctl_q[CTL_IDLE];
    assign cfg.div   = ctl_q[CTL_DIV +: DIV_W];
    assign idle_lvl  = ctl_q[CTL_IDLE];
    assign stat_bsy  = bsy_q;
    assign stat_rbf  = rbf_q;
    assign irq = ctl_q[CTL_EN] &&
                 ((!bsy_q && ctl_q[CTL_TXIE]) || (rbf_q && ctl_q[CTL_RXIE]));
endmodule

// File: rtl/spi_host_regs.sv
`timescale 1ns/1ps
module spi_host_regs
    import spi_regs_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_be,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              irq,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_n
);
    logic             start, eng_busy, eng_done, tick, idle_lvl;
    logic             stat_bsy, stat_rbf;
    logic [REG_W-1:0] tx_word, rx_word;
    logic [DIV_W-1:0] div_q;
    xfer_cfg_t        cfg;

    spi_reg_file #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .eng_busy  (eng_busy),
        .eng_done  (eng_done),
        .rx_word   (rx_word),
        .start     (start),
        .tx_word   (tx_word),
        .cfg       (cfg),
        .idle_lvl  (idle_lvl),
        .stat_bsy  (stat_bsy),
        .stat_rbf  (stat_rbf),
        .irq       (irq)
    );

    spi_shift_engine u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .cfg_in   (cfg),
        .tx_word  (tx_word),
        .idle_lvl (idle_lvl),
        .miso     (miso),
        .tick     (tick),
        .busy     (eng_busy),
        .done     (eng_done),
        .rx_word  (rx_word),
        .div_q    (div_q),
        .sclk     (sclk),
        .mosi     (mosi),
        .cs_n     (cs_n)
    );

    spi_clk_div #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (eng_busy),
        .div   (div_q),
        .tick  (tick)
    );
endmodule

// File: rtl/spi_host_regs_chk.sv
`timescale 1ns/1ps
module spi_host_regs_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              cs_n,
    input logic              sclk,
    input logic              idle_lvl,
    input logic              stat_bsy,
    input logic              stat_rbf,
    input logic              irq
);
    logic data_acc;
    assign data_acc = bus_sel && (bus_addr == '0);

    // R6
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (sclk == idle_lvl));

    // R3
    select_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> $past(data_acc && bus_wr));

    // R8
    done_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> (stat_bsy && stat_rbf));

    // R9
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && !bus_wr && cs_n) |=> !stat_rbf);

    // R10
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(bus_sel) || $rose(cs_n)));
endmodule

bind spi_host_regs spi_host_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .cs_n     (cs_n),
    .sclk     (sclk),
    .idle_lvl (idle_lvl),
    .stat_bsy (stat_bsy),
    .stat_rbf (stat_rbf),
    .irq      (irq)
);

// File: tb/tb_spi_host_regs.sv
`timescale 1ns/1ps
module tb_spi_host_regs;
    localparam int CLK_P  = 10;
    localparam int ADDR_W = 12;
    localparam int WD_CYC = 50000;
    localparam int NVEC   = 6;
    // {ctl, tx, slave response, expected MOSI word, expected DATA}
    localparam logic [79:0] VEC [NVEC] = '{
        {16'h0001, 16'h12A5, 16'h003C, 16'h00A5, 16'h003C},
        {16'h0005, 16'hBEEF, 16'h1234, 16'hBEEF, 16'h1234},
        {16'h0085, 16'h0F0F, 16'hC3A5, 16'h0F0F, 16'hC3A5},
        {16'h0181, 16'h0081, 16'h0066, 16'h0081, 16'h0066},
        {16'h0305, 16'h8001, 16'hFFFE, 16'h8001, 16'hFFFE},
        {16'h0401, 16'hFF00, 16'hAB5A, 16'h0000, 16'h005A}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0, bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [1:0]        bus_be = '0;
    logic [15:0]       bus_wdata = '0;
    logic [15:0]       bus_rdata;
    logic              irq, sclk, mosi, cs_n;
    logic              miso = 1'b0;

    int checks = 0, errors = 0;
    bit finished = 1'b0;

    // slave model state
    logic        sl_wide = 1'b0, sl_phase = 1'b0, sl_idle = 1'b0;
    logic [15:0] sl_resp = '0, sl_rx = '0;
    int          sl_idx = 0, sl_edges = 0;
    time         sl_t1 = 0, sl_t2 = 0;

    always #(CLK_P/2) clk = ~clk;

    spi_host_regs #(.ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq), .sclk(sclk), .mosi(mosi),
        .miso(miso), .cs_n(cs_n)
    );

    function automatic logic sl_bit(int k);
        int total = sl_wide ? 16 : 8;
        if (k >= total) return 1'b0;
        return sl_resp[total-1-k];
    endfunction

    always @(negedge cs_n) begin
        sl_idx = 0; sl_edges = 0; sl_rx = '0;
        if (!sl_phase) miso = sl_bit(0);
    end

    always @(sclk) begin
        if (!cs_n) begin
            sl_edges++;
            if (sl_edges == 1) sl_t1 = $time;
            else if (sl_edges == 2) sl_t2 = $time;
            if (!sl_phase) begin
                if (sclk != sl_idle) sl_rx = {sl_rx[14:0], mosi};
                else begin sl_idx++; miso = sl_bit(sl_idx); end
            end else begin
                if (sclk != sl_idle) miso = sl_bit(sl_idx);
                else begin sl_rx = {sl_rx[14:0], mosi}; sl_idx++; end
            end
        end
    end

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(logic [ADDR_W-1:0] a, logic [15:0] d, logic [1:0] be);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic bus_read(logic [ADDR_W-1:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic set_slave(logic [15:0] ctl, logic [15:0] resp);
        sl_wide = ctl[2]; sl_phase = ctl[7]; sl_idle = ctl[8]; sl_resp = resp;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (WD_CYC) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
    end

    initial begin
        logic [15:0] rd;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        chk("R1 cs_n", {15'b0, cs_n}, 16'h0001);
        chk("R1 sclk", {15'b0, sclk}, 16'h0000);
        chk("R1 irq", {15'b0, irq}, 16'h0000);
        bus_read(12'h000, rd); chk("R1 data", rd, 16'h0000);
        bus_read(12'h002, rd); chk("R1 ctl", rd, 16'h0000);
        bus_read(12'h004, rd); chk("R1 stat", rd, 16'h0000);

        // R2 control fields and byte lanes
        bus_write(12'h002, 16'hFFFF, 2'b11);
        bus_read(12'h002, rd); chk("R2 full write", rd, 16'hFFE5);
        bus_write(12'h002, 16'h0000, 2'b01);
        bus_read(12'h002, rd); chk("R2 low lane", rd, 16'hFF00);
        bus_write(12'h002, 16'h0000, 2'b11);

        // R12 unmapped, read-only and misaligned accesses
        bus_read(12'h006, rd); chk("R12 unmapped read", rd, 16'h0000);
        bus_write(12'h008, 16'hFFFF, 2'b11);
        bus_write(12'h004, 16'hFFFF, 2'b11);
        bus_write(12'h003, 16'h0001, 2'b11);
        bus_read(12'h002, rd); chk("R12 ctl untouched", rd, 16'h0000);
        bus_read(12'h004, rd); chk("R12 stat untouched", rd, 16'h0000);
        bus_read(12'h003, rd); chk("R12 misaligned read", rd, 16'h0000);

        // R11 data write while disabled
        bus_write(12'h000, 16'h0055, 2'b11);
        repeat (4) @(negedge clk);
        chk("R11 disabled cs_n", {15'b0, cs_n}, 16'h0001);
        bus_read(12'h004, rd); chk("R11 disabled stat", rd, 16'h0000);

        // R3 R4 R5 R6 R7 R8 R9 vector table
        for (int i = 0; i < NVEC; i++) begin
            logic [15:0] c, t, r, em, ed;
            int half;
            {c, t, r, em, ed} = VEC[i];
            set_slave(c, r);
            bus_write(12'h002, c, 2'b11);
            chk($sformatf("R6 idle level v%0d", i), {15'b0, sclk}, {15'b0, c[8]});
            bus_write(12'h000, t, 2'b11);
            chk($sformatf("R3 select low v%0d", i), {15'b0, cs_n}, 16'h0000);
            @(posedge cs_n);
            @(negedge clk);
            chk($sformatf("R3 R7 mosi word v%0d", i), sl_rx, em);
            half = int'((sl_t2 - sl_t1) / CLK_P);
            chk($sformatf("R6 half period v%0d", i), 16'(half), 16'((c[15:9] + 1) * 2));
            bus_read(12'h004, rd); chk($sformatf("R8 done stat v%0d", i), rd, 16'h0003);
            bus_read(12'h000, rd); chk($sformatf("R4 R5 R7 rx word v%0d", i), rd, ed);
            bus_read(12'h004, rd); chk($sformatf("R9 stat cleared v%0d", i), rd, 16'h0000);
        end

        // R11 write during a running transfer; R8 busy alone mid-transfer
        set_slave(16'h0605, 16'h2468);
        bus_write(12'h002, 16'h0605, 2'b11);
        bus_write(12'h000, 16'h1357, 2'b11);
        bus_read(12'h004, rd); chk("R8 busy mid transfer", rd, 16'h0001);
        bus_write(12'h000, 16'hFFFF, 2'b11);
        @(posedge cs_n);
        repeat (3) @(negedge clk);
        chk("R11 no restart", {15'b0, cs_n}, 16'h0001);
        chk("R11 first word kept", sl_rx, 16'h1357);
        bus_read(12'h000, rd); chk("R11 rx word", rd, 16'h2468);

        // R10 interrupt conditions
        bus_write(12'h002, 16'h0040, 2'b11);
        chk("R10 disabled", {15'b0, irq}, 16'h0000);
        bus_write(12'h002, 16'h0041, 2'b11);
        chk("R10 idle irq", {15'b0, irq}, 16'h0001);
        set_slave(16'h0041, 16'h0011);
        bus_write(12'h000, 16'h00C3, 2'b11);
        chk("R10 busy blocks idle irq", {15'b0, irq}, 16'h0000);
        @(posedge cs_n); @(negedge clk);
        chk("R10 done with idle irq only", {15'b0, irq}, 16'h0000);
        bus_read(12'h000, rd);
        chk("R10 idle irq after read", {15'b0, irq}, 16'h0001);
        bus_write(12'h002, 16'h0021, 2'b11);
        chk("R10 rx irq before data", {15'b0, irq}, 16'h0000);
        set_slave(16'h0021, 16'h0099);
        bus_write(12'h000, 16'h003C, 2'b11);
        @(posedge cs_n); @(negedge clk);
        chk("R10 rx irq on full", {15'b0, irq}, 16'h0001);
        bus_read(12'h000, rd);
        chk("R10 rx irq cleared", {15'b0, irq}, 16'h0000);
        chk("R5 rx byte", rd, 16'h0099);

        summary();
    end
endmodule